// File: doc/BRIEF.md
# PCI Slot Hotplug Register Controller

This block keeps the hotplug bookkeeping for a bus segment of up to 32 device slots. Three kinds of request come in on a strobe with a slot number: a hot insertion, a hot removal and a cold insertion, which is a device found at boot. The block keeps three per-slot vectors. The presence vector records which slots hold a device. The pending-removal vector records which slots have a removal waiting for firmware to finish it. The hotplug-enable vector records which slots may be hotplugged at all. Firmware sees these vectors through four 32-bit ports. It finishes a removal by writing a slot mask to the eject port. The block then reports the completed slot on an acknowledge strobe, which an external device-removal agent acts on.

A hot insertion or hot removal pulses an event flag for the general-purpose event status logic. The value firmware reads from the "inserted" port is not stored. It is formed on every read as presence AND hotplug-enable. As a result, every occupied hotpluggable slot is reported and gets a device check. When a slot that cannot be hotplugged is ejected, its presence bit is kept.

A controller state machine has three states. IDLE accepts requests and port accesses. DRAIN is entered from IDLE when `reinit` is asserted. It completes one pending removal per cycle, starting at the lowest slot, and leaves for REBUILD when none remain. REBUILD reloads hotplug-enable from the inverted fixed-slot mask and presence from the occupied-slot vector, then returns to IDLE. A hard reset clears all vectors and enters REBUILD. `busy` is high in every state other than IDLE.

Top module: `slot_hp_ctrl`

## Requirements
- R1: A read of port code 0 returns presence AND hotplug-enable. Port codes are 0 inserted, 1 pending removal, 2 eject/features, 3 removability. Every read returns its data with `rd_valid` one cycle after the request. The data reflects the state before any update made in the same cycle.
- R2: A request of kind 0 (hot insert) sets the slot's presence bit and pulses `hp_event` one cycle later.
- R3: A request of kind 1 (hot remove) sets the slot's pending-removal bit, leaves presence unchanged and pulses `hp_event` one cycle later.
- R4: A request of kind 2 (cold insert) sets the presence bit and raises no `hp_event`.
- R5: A nonzero write to port 2 selects the lowest set bit of the written value. It clears that slot's pending-removal bit, clears its presence bit if the slot is hotpluggable, and pulses `ej_ack_valid` with that slot on `ej_ack_slot` one cycle later.
- R6: A write of zero to port 2 changes no state and produces no acknowledge.
- R7: A read of port 2 returns 0, and a read of port 3 returns the hotplug-enable vector.
- R8: When an eject and a hot request name the same slot in the same cycle, the eject is applied first. A hot insert therefore leaves the slot present, and a hot remove leaves it pending.
- R9: After `reinit`, pending removals are completed one per cycle, lowest slot first, each with an acknowledge. After that, hotplug-enable becomes the inverse of `fixed_mask`, presence becomes `occupied`, and no removal is pending.
- R10: While `busy` is high, hotplug requests and port accesses are ignored.
- R11: Writes to ports 0, 1 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_valid | input | 1 | Hotplug request strobe |
| hp_kind | input | 2 | 0 hot insert, 1 hot remove, 2 cold insert, 3 none |
| hp_slot | input | 5 | Slot named by the request |
| fixed_mask | input | 32 | Slots that cannot be hotplugged |
| occupied | input | 32 | Slots holding a device, used by REBUILD |
| reinit | input | 1 | Start the drain and rebuild sequence |
| req_valid | input | 1 | Port access strobe |
| req_write | input | 1 | 1 write, 0 read |
| req_sel | input | 2 | Port code |
| wr_data | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| hp_event | output | 1 | Hotplug event pulse |
| ej_ack_valid | output | 1 | Eject completion strobe |
| ej_ack_slot | output | 5 | Slot whose eject completed |
| busy | output | 1 | Controller not in IDLE |

## Verification
The bench writes eject masks with several bits set, and also with bits for slots that have no pending removal. A design that cleared every bit in the mask, or the highest one, would report the wrong acknowledged slot. An eject and a hot insert for the same slot in the same cycle show whether the ordering is right: a design that applied the insert first would lose the device from the inserted view. A drain with three pending slots checks the order and count of acknowledges. Requests made during that drain must leave no trace, so a design that accepted them would show an extra slot after the rebuild. Writes of zero and writes to read-only ports are followed by reads that would expose any stray change.

// File: rtl/hp_pkg.sv
`timescale 1ns/1ps
package hp_pkg;
    typedef enum logic [1:0] {
        HP_INS  = 2'd0,
        HP_REM  = 2'd1,
        HP_COLD = 2'd2,
        HP_NONE = 2'd3
    } hp_kind_e;

    typedef enum logic [1:0] {
        PORT_UP    = 2'd0,
        PORT_DOWN  = 2'd1,
        PORT_EJECT = 2'd2,
        PORT_RMV   = 2'd3
    } port_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_REBUILD = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/hp_lowbit.sv
`timescale 1ns/1ps
module hp_lowbit #(
    parameter int N = 32,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        idx   = '0;
        found = |vec;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/hp_slot_state.sv
`timescale 1ns/1ps
module hp_slot_state #(
    parameter int N = 32,
    localparam int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ej_en,
    input  logic [W-1:0] ej_slot,
    input  logic         ins_en,
    input  logic [W-1:0] ins_slot,
    input  logic         rem_en,
    input  logic [W-1:0] rem_slot,
    input  logic         load_en,
    input  logic [N-1:0] load_enable,
    input  logic [N-1:0] load_present,
    output logic [N-1:0] present,
    output logic [N-1:0] pending,
    output logic [N-1:0] enable
);
    logic [N-1:0] pres_nx, pend_nx, en_nx;

    // eject first, then the hot request, so a same-slot insert survives
    always_comb begin
        pres_nx = present;
        pend_nx = pending;
        en_nx   = enable;
        if (ej_en) begin
            pend_nx[ej_slot] = 1'b0;
            if (enable[ej_slot]) pres_nx[ej_slot] = 1'b0;
        end
        if (ins_en) pres_nx[ins_slot] = 1'b1;
        if (rem_en) pend_nx[rem_slot] = 1'b1;
        if (load_en) begin
            en_nx   = load_enable;
            pres_nx = load_present;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            present <= '0;
            pending <= '0;
            enable  <= '0;
        end else begin
            present <= pres_nx;
            pending <= pend_nx;
            enable  <= en_nx;
        end
    end

    p_eject_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ej_en && !rem_en) |=> !pending[$past(ej_slot)]);

    p_insert_after_eject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && !load_en) |=> present[$past(ins_slot)]);

    p_remove_keeps_presence_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_en && !ej_en && !ins_en && !load_en) |=> $stable(present));
endmodule

// File: rtl/hp_read_port.sv
`timescale 1ns/1ps
module hp_read_port
    import hp_pkg::*;
#(
    parameter int N      = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [1:0]        sel,
    input  logic [N-1:0]      present,
    input  logic [N-1:0]      pending,
    input  logic [N-1:0]      enable,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [N-1:0] word;

    always_comb begin
        unique case (sel)
            PORT_UP:    word = present & enable;
            PORT_DOWN:  word = pending;
            PORT_EJECT: word = '0;
            PORT_RMV:   word = enable;
            default:    word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? DATA_W'(word) : '0;
        end
    end

    p_up_view_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == PORT_UP) |=> rd_data == DATA_W'($past(present & enable)));

    p_features_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == PORT_EJECT) |=> rd_data == '0);
endmodule

// File: rtl/slot_hp_ctrl.sv
`timescale 1ns/1ps
module slot_hp_ctrl
    import hp_pkg::*;
#(
    parameter int NSLOTS = 32,
    parameter int DATA_W = 32,
    localparam int SLOT_W = $clog2(NSLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hp_valid,
    input  logic [1:0]        hp_kind,
    input  logic [SLOT_W-1:0] hp_slot,
    input  logic [NSLOTS-1:0] fixed_mask,
    input  logic [NSLOTS-1:0] occupied,
    input  logic              reinit,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              hp_event,
    output logic              ej_ack_valid,
    output logic [SLOT_W-1:0] ej_ack_slot,
    output logic              busy
);
    ctl_state_e state, state_nx;

    logic [NSLOTS-1:0] slot_pres, slot_pend, slot_en;
    logic [NSLOTS-1:0] pick_vec;
    logic              pick_found;
    logic [SLOT_W-1:0] pick_idx;

    logic idle, acc, ej_en, ins_en, rem_en, load_en, rd_en, evt_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_REBUILD;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (reinit) state_nx = ST_DRAIN;
            ST_DRAIN:   if (!pick_found) state_nx = ST_REBUILD;
            ST_REBUILD: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // control outputs per state
    always_comb begin
        idle     = 1'b0;
        pick_vec = '0;
        ej_en    = 1'b0;
        load_en  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                idle     = 1'b1;
                pick_vec = wr_data[NSLOTS-1:0];
                ej_en    = req_valid && req_write && req_sel == PORT_EJECT && pick_found;
            end
            ST_DRAIN: begin
                pick_vec = slot_pend;
                ej_en    = pick_found;
            end
            ST_REBUILD: load_en = 1'b1;
            default: ;
        endcase
        acc    = idle && req_valid;
        rd_en  = acc && !req_write;
        ins_en = idle && hp_valid && (hp_kind == HP_INS || hp_kind == HP_COLD);
        rem_en = idle && hp_valid && hp_kind == HP_REM;
        evt_nx = idle && hp_valid && (hp_kind == HP_INS || hp_kind == HP_REM);
    end

    assign busy = !idle;

    hp_lowbit #(.N(NSLOTS)) u_pick (
        .vec   (pick_vec),
        .found (pick_found),
        .idx   (pick_idx)
    );

    hp_slot_state #(.N(NSLOTS)) u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .ej_en        (ej_en),
        .ej_slot      (pick_idx),
        .ins_en       (ins_en),
        .ins_slot     (hp_slot),
        .rem_en       (rem_en),
        .rem_slot     (hp_slot),
        .load_en      (load_en),
        .load_enable  (~fixed_mask),
        .load_present (occupied),
        .present      (slot_pres),
        .pending      (slot_pend),
        .enable       (slot_en)
    );

    hp_read_port #(.N(NSLOTS), .DATA_W(DATA_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .sel      (req_sel),
        .present  (slot_pres),
        .pending  (slot_pend),
        .enable   (slot_en),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hp_event     <= 1'b0;
            ej_ack_valid <= 1'b0;
            ej_ack_slot  <= '0;
        end else begin
            hp_event     <= evt_nx;
            ej_ack_valid <= ej_en;
            ej_ack_slot  <= ej_en ? pick_idx : '0;
        end
    end

    p_event_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hp_event |-> $past(hp_valid && !busy && (hp_kind == HP_INS || hp_kind == HP_REM)));

    p_cold_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_valid && !busy && hp_kind == HP_COLD) |=> !hp_event);

    p_zero_eject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_sel == PORT_EJECT && wr_data == '0 && !busy)
        |=> (!ej_ack_valid && $stable(slot_pend)));

    p_rebuild_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REBUILD) |=> (slot_en == ~$past(fixed_mask) && slot_pend == '0));

    p_busy_no_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!hp_event && !rd_valid));

    p_read_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write && !busy));
endmodule

// File: tb/tb_slot_hp_ctrl.sv
`timescale 1ns/1ps
module tb_slot_hp_ctrl;
    localparam logic [31:0] FIXED = 32'h0000_0011;
    localparam logic [31:0] OCC   = 32'h0000_0013;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, hp_valid, reinit, req_valid, req_write;
    logic [1:0]  hp_kind, req_sel;
    logic [4:0]  hp_slot;
    logic [31:0] wr_data;
    logic        rd_valid, hp_event, ej_ack_valid, busy;
    logic [31:0] rd_data;
    logic [4:0]  ej_ack_slot;

    slot_hp_ctrl dut (
        .clk(clk), .rst_n(rst_n), .hp_valid(hp_valid), .hp_kind(hp_kind),
        .hp_slot(hp_slot), .fixed_mask(FIXED), .occupied(OCC), .reinit(reinit),
        .req_valid(req_valid), .req_write(req_write), .req_sel(req_sel),
        .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
        .hp_event(hp_event), .ej_ack_valid(ej_ack_valid),
        .ej_ack_slot(ej_ack_slot), .busy(busy)
    );

    typedef struct {
        logic        rv;
        logic [31:0] rd;
        logic        ev;
        logic        av;
        logic [4:0]  as;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    logic [31:0] m_pres, m_pend, m_en;

    function automatic logic [4:0] lowest(input logic [31:0] v);
        logic [4:0] r = '0;
        for (int i = 31; i >= 0; i--) if (v[i]) r = 5'(i);
        return r;
    endfunction

    // monitor: pops one expectation per clock, 2 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (rd_valid !== e.rv || (e.rv && rd_data !== e.rd)) begin
                    errors++;
                    $display("FAIL %s read: valid=%0b data=%h expected valid=%0b data=%h",
                             e.tag, rd_valid, rd_data, e.rv, e.rd);
                end
                if (hp_event !== e.ev) begin
                    errors++;
                    $display("FAIL %s event: got %0b expected %0b", e.tag, hp_event, e.ev);
                end
                if (ej_ack_valid !== e.av || (e.av && ej_ack_slot !== e.as)) begin
                    errors++;
                    $display("FAIL %s ack: valid=%0b slot=%0d expected valid=%0b slot=%0d",
                             e.tag, ej_ack_valid, ej_ack_slot, e.av, e.as);
                end
            end
        end
    end

    task automatic drive(input logic hv, input logic [1:0] k, input logic [4:0] s,
                         input logic rq, input logic wr, input logic [1:0] sel,
                         input logic [31:0] wd, input logic ri);
        hp_valid = hv; hp_kind = k; hp_slot = s;
        req_valid = rq; req_write = wr; req_sel = sel; wr_data = wd; reinit = ri;
        @(negedge clk);
        hp_valid = 0; req_valid = 0; req_write = 0; reinit = 0; wr_data = '0;
    endtask

    // one idle-state cycle: expectation from the requirement model, then drive
    task automatic tick(input logic hv, input logic [1:0] k, input logic [4:0] s,
                        input logic rq, input logic wr, input logic [1:0] sel,
                        input logic [31:0] wd, input string tag);
        exp_t e;
        e.rv = 0; e.rd = '0; e.ev = 0; e.av = 0; e.as = '0; e.tag = tag;
        if (rq && !wr) begin
            e.rv = 1;
            case (sel)
                2'd0: e.rd = m_pres & m_en;
                2'd1: e.rd = m_pend;
                2'd2: e.rd = '0;
                default: e.rd = m_en;
            endcase
        end
        if (rq && wr && sel == 2'd2 && wd != 0) begin
            logic [4:0] x;
            x = lowest(wd);
            m_pend[x] = 1'b0;
            if (m_en[x]) m_pres[x] = 1'b0;
            e.av = 1; e.as = x;
        end
        if (hv) begin
            if (k == 2'd0) begin m_pres[s] = 1'b1; e.ev = 1; end
            if (k == 2'd1) begin m_pend[s] = 1'b1; e.ev = 1; end
            if (k == 2'd2) m_pres[s] = 1'b1;
        end
        exp_q.push_back(e);
        drive(hv, k, s, rq, wr, sel, wd, 1'b0);
    endtask

    task automatic rd(input logic [1:0] sel, input string tag);
        tick(0, 2'd3, 0, 1, 0, sel, 0, tag);
    endtask

    task automatic quiet(input string tag);
        exp_t e;
        e.rv = 0; e.rd = '0; e.ev = 0; e.av = 0; e.as = '0; e.tag = tag;
        exp_q.push_back(e);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; hp_valid = 0; hp_kind = 2'd3; hp_slot = 0; reinit = 0;
        req_valid = 0; req_write = 0; req_sel = 0; wr_data = 0;
        m_pres = 0; m_pend = 0; m_en = 0;
        repeat (3) @(negedge clk);
        checks++;
        if (rd_valid !== 0 || hp_event !== 0 || ej_ack_valid !== 0) begin
            errors++;
            $display("FAIL reset R1: outputs %0b%0b%0b expected 000", rd_valid, hp_event, ej_ack_valid);
        end
        rst_n = 1;
        quiet("R9 reset rebuild");
        drive(0, 2'd3, 0, 0, 0, 0, 0, 0);
        m_en = ~FIXED; m_pres = OCC; m_pend = 0;

        rd(2'd0, "R1 inserted view after reset");
        rd(2'd3, "R7 removability");
        rd(2'd2, "R7 features");
        rd(2'd1, "R3 pending empty");

        tick(1, 2'd0, 5'd7, 0, 0, 0, 0, "R2 hot insert");
        rd(2'd0, "R2 inserted view");
        tick(1, 2'd2, 5'd9, 0, 0, 0, 0, "R4 cold insert");
        rd(2'd0, "R4 inserted view");
        tick(1, 2'd1, 5'd7, 0, 0, 0, 0, "R3 hot remove");
        rd(2'd1, "R3 pending");
        rd(2'd0, "R3 presence kept");
        tick(1, 2'd1, 5'd4, 0, 0, 0, 0, "R3 remove fixed slot");
        tick(0, 2'd3, 0, 1, 1, 2'd2, 32'h90, "R5 eject lowest of two");
        rd(2'd1, "R5 pending after eject");
        tick(0, 2'd3, 0, 1, 1, 2'd2, 32'hA0, "R5 eject idle slot");
        tick(0, 2'd3, 0, 1, 1, 2'd2, 32'h80, "R5 eject slot 7");
        rd(2'd0, "R5 inserted after eject");
        rd(2'd1, "R5 pending cleared");
        tick(1, 2'd1, 5'd2, 0, 0, 0, 0, "R6 setup remove");
        tick(0, 2'd3, 0, 1, 1, 2'd2, 32'h0, "R6 zero eject");
        rd(2'd1, "R6 pending unchanged");
        tick(0, 2'd3, 0, 1, 1, 2'd0, 32'hFFFF_FFFF, "R11 write inserted port");
        tick(0, 2'd3, 0, 1, 1, 2'd1, 32'h0, "R11 write pending port");
        tick(0, 2'd3, 0, 1, 1, 2'd3, 32'h0, "R11 write removability port");
        rd(2'd0, "R11 inserted unchanged");
        rd(2'd1, "R11 pending unchanged");
        rd(2'd3, "R11 removability unchanged");
        tick(1, 2'd0, 5'd9, 1, 1, 2'd2, 32'h200, "R8 eject plus insert");
        rd(2'd0, "R8 slot stays present");
        tick(1, 2'd1, 5'd9, 1, 1, 2'd2, 32'h200, "R8 eject plus remove");
        rd(2'd1, "R8 slot stays pending");
        tick(1, 2'd1, 5'd3, 0, 0, 0, 0, "R9 setup remove");
        rd(2'd1, "R9 pending before drain");

        // drain: pending bits 2, 3, 9
        quiet("R9 reinit");
        drive(0, 2'd3, 0, 0, 0, 0, 0, 1);
        begin
            bit first = 1;
            while (m_pend != 0) begin
                exp_t e;
                e.rv = 0; e.rd = '0; e.ev = 0; e.av = 1; e.as = lowest(m_pend);
                e.tag = "R9 drain order";
                m_pend[e.as] = 1'b0;
                exp_q.push_back(e);
                if (first) drive(1, 2'd0, 5'd20, 1, 0, 2'd0, 0, 0);
                else       drive(0, 2'd3, 0, 0, 0, 0, 0, 0);
                first = 0;
            end
        end
        quiet("R10 drain end");
        drive(1, 2'd1, 5'd21, 0, 0, 0, 0, 0);
        quiet("R10 rebuild");
        drive(0, 2'd3, 0, 1, 0, 2'd1, 0, 0);
        m_en = ~FIXED; m_pres = OCC; m_pend = 0;
        rd(2'd0, "R10 busy insert ignored");
        rd(2'd1, "R9 pending empty after drain");
        rd(2'd3, "R9 removability reloaded");
        quiet("tail");
        drive(0, 2'd3, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule